// File: doc/BRIEF.md
# Serial ADC Slave Interface Model

This block is a synthesizable stand-in for the digital side of a serial 10-bit analog-to-digital converter. A bus master drives a select line, a serial clock and a serial data line. The block looks for a start bit, takes in an 8-bit control byte and decodes it. It then returns a 12-bit result on its serial output: ten data bits followed by two sub-LSB bits. The converter itself is not modelled. A parallel 10-bit sample input and a 2-bit sub-LSB input supply the values that are sent, so a testbench or a system model can choose exactly what the master reads.

Every serial pin is oversampled in the block's own clock domain. The pins pass through a configurable synchronizer and an edge detector, and all state changes happen on `clk`. The serial clock must therefore stay low for at least SYNC_STAGES+3 cycles of `clk`, and high for the same minimum. A master using 8-bit transfers and a start bit at the first clock sees the result in its second and third bytes. There is one leading zero before the result and three trailing zeros after it.

Top module: `sadc_slave`

## Requirements
- R1: The serial data line is sampled only on rising serial-clock edges while the select line is low. After select falls, 0 bits are ignored, and the first 1 becomes bit 7 of the control byte. Clock edges while select is high have no effect.
- R2: Control byte fields are as follows. Bits 6:4 are the channel, shown on `chan_o` once the eighth bit is taken and held until the next control byte. Bit 3 is the polarity: 1 for unipolar, 0 for bipolar. Bits 1:0 are the clock mode: 2'b10 is internal, and 2'b11, 2'b01 and 2'b00 all use external timing. Bit 2 has no effect.
- R3: `ser_do` changes only after a falling serial-clock edge, or when select goes high.
- R4: In external timing, `rdy_strb` rises on the first falling edge after the eighth control bit. It stays high for exactly one serial-clock period and falls on the next falling edge, which is the edge that drives the result MSB.
- R5: The result goes out MSB first: sample bits 9..0, then `sub_lsb_i[1]`, then `sub_lsb_i[0]`, one bit per falling edge. After that `ser_do` is 0 until select rises. Counting rising edges from the start bit as 1, the master samples the result on edges 10 to 21.
- R6: In unipolar mode the sample is sent unchanged. In bipolar mode its bit 9 is inverted, which turns an offset-binary sample into two's complement.
- R7: The sample and sub-LSB inputs are captured when the eighth control bit is taken. Changes to them after that do not affect the result being sent.
- R8: Raising select forces `ser_do` and `rdy_strb` low and abandons any transfer in progress. After select falls again, start-bit detection works as it did after reset.
- R9: From the eighth control bit until the last sub-LSB has been driven, 1s on the data line are ignored. After that, while select stays low, a new start bit begins a new control byte.
- R10: In internal clock mode, `rdy_strb` stays low and `ser_do` stays low for INT_CONV_CYC cycles of `clk` after the control byte. `rdy_strb` then rises and stays high until the next falling edge, which drives the MSB and clears it.
- R11: `ser_do` is low whenever no result bit is being driven, including during the control byte and while the strobe is high.
- R12: During and after reset, `ser_do`, `rdy_strb` and `chan_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Active-low select that frames a transfer |
| ser_clk | input | 1 | Serial clock from the master |
| ser_di | input | 1 | Serial control data from the master |
| sample_i | input | SAMPLE_W | Conversion value to report |
| sub_lsb_i | input | SUB_W | Sub-LSB bits appended after the data bits |
| ser_do | output | 1 | Serial result to the master |
| rdy_strb | output | 1 | Result-ready strobe |
| chan_o | output | CHAN_W | Channel decoded from the last control byte |

## Verification
The bench builds the block with SYNC_STAGES=3 and INT_CONV_CYC=40, and runs the serial clock at a half period of six block clocks. With three synchronizer stages the timing margin is at its minimum: every output change has to land inside one serial-clock phase, so any extra register stage would shift the bits the bench reads. The short conversion count makes it possible to observe the internal-mode strobe both before and after it rises, and to read the result that follows it, within a few hundred cycles.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Output sequencer states
  typedef enum logic [2:0] {
    TX_IDLE,   // nothing to send, waiting for a control byte
    TX_ARM,    // external timing: strobe rises on next falling edge
    TX_CONV,   // internal timing: conversion counter running
    TX_STRB,   // strobe high, MSB goes out on next falling edge
    TX_SHIFT,  // result bits being driven
    TX_TAIL    // result done, zeros until select rises
  } tx_state_e;

  // Clock-mode field value that selects the internal conversion clock
  localparam logic [1:0] MODE_INTERNAL = 2'b10;

  function automatic logic uses_int_clk(input logic [1:0] mode_f);
    return mode_f == MODE_INTERNAL;
  endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_n = d;
    end else begin : g_multi
      always_comb chain_n = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sadc_edge.sv
module sadc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic sel_n_s,
  output logic rise_p,
  output logic fall_p,
  output logic idle
);

  logic sclk_d;
  logic sclk_d_n;

  always_comb sclk_d_n = sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_d_n;
  end

  assign idle   = sel_n_s;
  assign rise_p = sclk_s & ~sclk_d & ~sel_n_s;
  assign fall_p = ~sclk_s & sclk_d & ~sel_n_s;

endmodule

// File: rtl/sadc_rx.sv
module sadc_rx #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_p,
  input  logic              idle,
  input  logic              enable,
  input  logic              bit_s,
  output logic              byte_v,
  output logic [CTRL_W-1:0] byte_q
);

  localparam int CW = $clog2(CTRL_W);

  logic              hunt_q, hunt_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [CTRL_W-1:0] sr_q, sr_n;
  logic              v_q, v_n;

  always_comb begin
    hunt_n = hunt_q;
    cnt_n  = cnt_q;
    sr_n   = sr_q;
    v_n    = 1'b0;
    if (idle) begin
      hunt_n = 1'b1;
      cnt_n  = '0;
    end else if (rise_p && enable) begin
      if (hunt_q) begin
        if (bit_s) begin
          hunt_n = 1'b0;
          sr_n   = {{(CTRL_W-1){1'b0}}, 1'b1};
          cnt_n  = CW'(1);
        end
      end else begin
        sr_n = {sr_q[CTRL_W-2:0], bit_s};
        if (cnt_q == CW'(CTRL_W-1)) begin
          v_n    = 1'b1;
          hunt_n = 1'b1;
          cnt_n  = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_q <= 1'b1;
      cnt_q  <= '0;
      sr_q   <= '0;
      v_q    <= 1'b0;
    end else begin
      hunt_q <= hunt_n;
      cnt_q  <= cnt_n;
      sr_q   <= sr_n;
      v_q    <= v_n;
    end
  end

  assign byte_v = v_q;
  assign byte_q = sr_q;

endmodule

// File: rtl/sadc_tx.sv
module sadc_tx
  import sadc_pkg::*;
#(
  parameter int SAMPLE_W     = 10,
  parameter int SUB_W        = 2,
  parameter int CTRL_W       = 8,
  parameter int CHAN_LSB     = 4,
  parameter int CHAN_W       = 3,
  parameter int POL_BIT      = 3,
  parameter int MODE_LSB     = 0,
  parameter int INT_CONV_CYC = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_p,
  input  logic                idle,
  input  logic                byte_v,
  input  logic [CTRL_W-1:0]   byte_q,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SUB_W-1:0]    sub_i,
  output logic                dout,
  output logic                strb,
  output logic [CHAN_W-1:0]   chan_o,
  output logic                accept
);

  localparam int WORD_W = SAMPLE_W + SUB_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int CONV_W = $clog2(INT_CONV_CYC + 1);

  tx_state_e            st_q, st_n;
  logic [WORD_W-1:0]    word_q, word_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [CONV_W-1:0]    conv_q, conv_n;
  logic                 dout_q, dout_n;
  logic                 strb_q, strb_n;
  logic [CHAN_W-1:0]    chan_q, chan_n;
  logic [SAMPLE_W-1:0]  coded;
  logic                 unused_ctrl_bits;

  assign unused_ctrl_bits = ^byte_q;

  // Output coding: bipolar flips the sign bit of the offset-binary sample
  always_comb begin
    coded = sample_i;
    if (!byte_q[POL_BIT]) coded[SAMPLE_W-1] = ~sample_i[SAMPLE_W-1];
  end

  always_comb begin
    st_n   = st_q;
    word_n = word_q;
    cnt_n  = cnt_q;
    conv_n = conv_q;
    dout_n = dout_q;
    strb_n = strb_q;
    chan_n = chan_q;
    if (idle) begin
      st_n   = TX_IDLE;
      dout_n = 1'b0;
      strb_n = 1'b0;
      cnt_n  = '0;
    end else begin
      unique case (st_q)
        TX_IDLE, TX_TAIL: begin
          dout_n = 1'b0;
          if (byte_v) begin
            word_n = {coded, sub_i};
            chan_n = byte_q[CHAN_LSB +: CHAN_W];
            cnt_n  = '0;
            if (uses_int_clk(byte_q[MODE_LSB +: 2])) begin
              st_n   = TX_CONV;
              conv_n = CONV_W'(INT_CONV_CYC - 1);
            end else begin
              st_n = TX_ARM;
            end
          end
        end
        TX_ARM: begin
          if (fall_p) begin
            strb_n = 1'b1;
            st_n   = TX_STRB;
          end
        end
        TX_CONV: begin
          if (conv_q == '0) begin
            strb_n = 1'b1;
            st_n   = TX_STRB;
          end else begin
            conv_n = conv_q - 1'b1;
          end
        end
        TX_STRB: begin
          if (fall_p) begin
            strb_n = 1'b0;
            dout_n = word_q[WORD_W-1];
            word_n = word_q << 1;
            cnt_n  = CNT_W'(1);
            st_n   = TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (fall_p) begin
            if (cnt_q == CNT_W'(WORD_W)) begin
              dout_n = 1'b0;
              st_n   = TX_TAIL;
            end else begin
              dout_n = word_q[WORD_W-1];
              word_n = word_q << 1;
              cnt_n  = cnt_q + 1'b1;
            end
          end
        end
        default: st_n = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      word_q <= '0;
      cnt_q  <= '0;
      conv_q <= '0;
      dout_q <= 1'b0;
      strb_q <= 1'b0;
      chan_q <= '0;
    end else begin
      st_q   <= st_n;
      word_q <= word_n;
      cnt_q  <= cnt_n;
      conv_q <= conv_n;
      dout_q <= dout_n;
      strb_q <= strb_n;
      chan_q <= chan_n;
    end
  end

  assign dout   = dout_q;
  assign strb   = strb_q;
  assign chan_o = chan_q;
  assign accept = (st_q == TX_IDLE) || (st_q == TX_TAIL);

endmodule

// File: rtl/sadc_slave.sv
module sadc_slave #(
  parameter int SAMPLE_W     = 10,
  parameter int SUB_W        = 2,
  parameter int CTRL_W       = 8,
  parameter int CHAN_LSB     = 4,
  parameter int CHAN_W       = 3,
  parameter int POL_BIT      = 3,
  parameter int MODE_LSB     = 0,
  parameter int SYNC_STAGES  = 2,
  parameter int INT_CONV_CYC = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_sel_n,
  input  logic                ser_clk,
  input  logic                ser_di,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SUB_W-1:0]    sub_lsb_i,
  output logic                ser_do,
  output logic                rdy_strb,
  output logic [CHAN_W-1:0]   chan_o
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0]  pins_s;
  logic              sel_n_s, sclk_s, di_s;
  logic              rise_p, fall_p, idle;
  logic              byte_v;
  logic [CTRL_W-1:0] byte_q;
  logic              accept;

  sadc_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_sel_n, ser_clk, ser_di}),
    .q     (pins_s)
  );

  assign {sel_n_s, sclk_s, di_s} = pins_s;

  sadc_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (sclk_s),
    .sel_n_s (sel_n_s),
    .rise_p  (rise_p),
    .fall_p  (fall_p),
    .idle    (idle)
  );

  sadc_rx #(.CTRL_W(CTRL_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_p (rise_p),
    .idle   (idle),
    .enable (accept),
    .bit_s  (di_s),
    .byte_v (byte_v),
    .byte_q (byte_q)
  );

  sadc_tx #(
    .SAMPLE_W     (SAMPLE_W),
    .SUB_W        (SUB_W),
    .CTRL_W       (CTRL_W),
    .CHAN_LSB     (CHAN_LSB),
    .CHAN_W       (CHAN_W),
    .POL_BIT      (POL_BIT),
    .MODE_LSB     (MODE_LSB),
    .INT_CONV_CYC (INT_CONV_CYC)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_p   (fall_p),
    .idle     (idle),
    .byte_v   (byte_v),
    .byte_q   (byte_q),
    .sample_i (sample_i),
    .sub_i    (sub_lsb_i),
    .dout     (ser_do),
    .strb     (rdy_strb),
    .chan_o   (chan_o),
    .accept   (accept)
  );

endmodule

// File: rtl/sadc_slave_chk.sv
module sadc_slave_chk #(
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise_p,
  input logic              fall_p,
  input logic              idle,
  input logic              byte_v,
  input logic              ser_do,
  input logic              rdy_strb,
  input logic [CHAN_W-1:0] chan_o
);

  // R3: serial output moves only after a falling edge or a select release
  a_r3_do_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_do) |-> ($past(fall_p) || $past(idle)));

  // R4 / R10: strobe drops only on a falling edge or a select release
  a_r4_strb_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_strb) |-> ($past(fall_p) || $past(idle)));

  // R11: no result bit is driven while the strobe is high
  a_r11_quiet_strb: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_strb |-> !ser_do);

  // R8: select high clears both outputs on the next cycle
  a_r8_sel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (!ser_do && !rdy_strb));

  // R1: a control byte completes only after a rising serial edge
  a_r1_byte_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    byte_v |-> $past(rise_p));

  // R2: the channel report changes only when a control byte lands
  a_r2_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_o) |-> $past(byte_v));

endmodule

bind sadc_slave sadc_slave_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rise_p   (rise_p),
  .fall_p   (fall_p),
  .idle     (idle),
  .byte_v   (byte_v),
  .ser_do   (ser_do),
  .rdy_strb (rdy_strb),
  .chan_o   (chan_o)
);

// File: tb/sim_sadc_slave.sv
`timescale 1ns/1ps
module sim_sadc_slave;

  localparam int HALF = 6;

  logic       clk;
  logic       rst_n;
  logic       ser_sel_n;
  logic       ser_clk;
  logic       ser_di;
  logic [9:0] sample_i;
  logic [1:0] sub_lsb_i;
  logic       ser_do;
  logic       rdy_strb;
  logic [2:0] chan_o;

  int n_chk = 0;
  int n_bad = 0;

  sadc_slave #(
    .SYNC_STAGES  (3),
    .INT_CONV_CYC (40)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_sel_n (ser_sel_n),
    .ser_clk   (ser_clk),
    .ser_di    (ser_di),
    .sample_i  (sample_i),
    .sub_lsb_i (sub_lsb_i),
    .ser_do    (ser_do),
    .rdy_strb  (rdy_strb),
    .chan_o    (chan_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_ctrl(input logic [2:0] ch, input logic uni,
                                         input logic b2, input logic [1:0] md);
    return {1'b1, ch, uni, b2, md};
  endfunction

  function automatic logic [11:0] exp_word(input logic [9:0] smp, input logic uni,
                                           input logic [1:0] sb);
    return {(uni ? smp[9] : ~smp[9]), smp[8:0], sb};
  endfunction

  task automatic bit_cyc(input logic b, output logic o, output logic s);
    @(negedge clk);
    ser_di = b;
    repeat (HALF) @(negedge clk);
    o = ser_do;
    s = rdy_strb;
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic xfer8(input logic [7:0] t, output logic [7:0] r, output logic [7:0] s);
    for (int i = 7; i >= 0; i--) begin
      logic o, st;
      bit_cyc(t[i], o, st);
      r[i] = o;
      s[i] = st;
    end
  endtask

  task automatic sel_low();
    @(negedge clk);
    ser_sel_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_high();
    @(negedge clk);
    ser_sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // Full frame: optional leading zeros, control byte, two read bytes
  task automatic frame_check(input string req, input logic [7:0] ctrl,
                             input logic [9:0] smp, input logic [1:0] sb,
                             input logic [9:0] smp_late, input int nlead);
    logic [7:0]  r1, r2, r3, s1, s2, s3;
    logic [11:0] e;
    logic        o, st;
    logic        lead_ok;
    lead_ok = 1'b1;
    sample_i  = smp;
    sub_lsb_i = sb;
    sel_low();
    for (int i = 0; i < nlead; i++) begin
      bit_cyc(1'b0, o, st);
      if (o !== 1'b0) lead_ok = 1'b0;
    end
    xfer8(ctrl, r1, s1);
    // R7: inputs change after capture
    sample_i  = smp_late;
    sub_lsb_i = ~sb;
    if (ctrl[1:0] == 2'b10) begin
      @(negedge clk);
      chk(rdy_strb == 1'b0, "R10", "strobe low at conversion start", 32'(rdy_strb), 0);
      repeat (20) @(negedge clk);
      chk(rdy_strb == 1'b0 && ser_do == 1'b0, "R10", "strobe/do low mid conversion",
          {ser_do, rdy_strb}, 0);
      repeat (40) @(negedge clk);
      chk(rdy_strb == 1'b1, "R10", "strobe high after conversion", 32'(rdy_strb), 1);
    end
    xfer8(8'h00, r2, s2);
    xfer8(8'h00, r3, s3);
    e = exp_word(smp, ctrl[3], sb);
    chk(lead_ok, "R1", "do low during leading zeros", 32'(lead_ok), 1);
    chk(r1 == 8'h00, "R11", "do during control byte", r1, 8'h00);
    chk(r2 == {1'b0, e[11:5]}, req, "first read byte", r2, {1'b0, e[11:5]});
    chk(r3 == {e[4:0], 3'b000}, "R5", "second read byte", r3, {e[4:0], 3'b000});
    chk({s1, s2, s3} == 24'h008000, "R4", "strobe pattern", {s1, s2, s3}, 24'h008000);
    chk(chan_o == ctrl[6:4], "R2", "channel report", chan_o, ctrl[6:4]);
    sel_high();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ser_sel_n = 1'b1; ser_clk = 1'b0; ser_di = 1'b0;
    sample_i = '0; sub_lsb_i = '0;
    repeat (5) @(negedge clk);
    chk(ser_do == 0 && rdy_strb == 0 && chan_o == 0, "R12", "outputs in reset",
        {ser_do, rdy_strb, chan_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(ser_do == 0 && rdy_strb == 0 && chan_o == 0, "R12", "outputs after reset",
        {ser_do, rdy_strb, chan_o}, 0);
  endtask

  task automatic t_basic();
    frame_check("R5", mk_ctrl(3'd5, 1'b1, 1'b0, 2'b11), 10'h2A5, 2'b10, 10'h0F0, 0);
    frame_check("R2", mk_ctrl(3'd7, 1'b1, 1'b1, 2'b00), 10'h0C3, 2'b01, 10'h3FF, 0);
  endtask

  task automatic t_bipolar();
    frame_check("R6", mk_ctrl(3'd3, 1'b0, 1'b0, 2'b11), 10'h155, 2'b01, 10'h000, 0);
    frame_check("R6", mk_ctrl(3'd1, 1'b0, 1'b1, 2'b01), 10'h2AA, 2'b11, 10'h155, 0);
  endtask

  task automatic t_sel_high_ignored();
    logic o, st;
    for (int i = 0; i < 6; i++) begin
      bit_cyc(1'b1, o, st);
      chk(o == 1'b0 && st == 1'b0, "R1", "outputs while select high", {o, st}, 0);
    end
    frame_check("R1", mk_ctrl(3'd6, 1'b1, 1'b0, 2'b11), 10'h1E7, 2'b10, 10'h000, 3);
  endtask

  task automatic t_internal();
    frame_check("R10", mk_ctrl(3'd4, 1'b1, 1'b0, 2'b10), 10'h31C, 2'b01, 10'h0AA, 0);
  endtask

  task automatic t_readout_ignores_di();
    logic [7:0]  r, s, r2, s2, r3, s3;
    logic [12:0] q;
    logic [11:0] e1, e2;
    logic        o, st;
    sample_i  = 10'h1C3;
    sub_lsb_i = 2'b11;
    sel_low();
    xfer8(mk_ctrl(3'd1, 1'b1, 1'b0, 2'b11), r, s);
    for (int i = 12; i >= 0; i--) begin
      bit_cyc(1'b1, o, st);
      q[i] = o;
    end
    e1 = exp_word(10'h1C3, 1'b1, 2'b11);
    chk(q == {1'b0, e1}, "R9", "result with ones on data line", q, {1'b0, e1});
    sample_i  = 10'h04E;
    sub_lsb_i = 2'b01;
    xfer8(mk_ctrl(3'd2, 1'b0, 1'b0, 2'b11), r, s);
    chk(r == 8'h00, "R5", "do zero after sub-LSBs", r, 8'h00);
    xfer8(8'h00, r2, s2);
    xfer8(8'h00, r3, s3);
    e2 = exp_word(10'h04E, 1'b0, 2'b01);
    chk({r2, r3} == {1'b0, e2, 3'b000}, "R9", "back-to-back second result",
        {r2, r3}, {1'b0, e2, 3'b000});
    chk(chan_o == 3'd2, "R9", "back-to-back channel", chan_o, 3'd2);
    sel_high();
  endtask

  task automatic t_abort();
    logic [7:0] r, s;
    logic       o, st;
    sample_i  = 10'h3FF;
    sub_lsb_i = 2'b11;
    sel_low();
    xfer8(mk_ctrl(3'd4, 1'b1, 1'b0, 2'b11), r, s);
    repeat (5) @(negedge clk);
    chk(rdy_strb == 1'b1, "R4", "strobe up after control byte", 32'(rdy_strb), 1);
    sel_high();
    chk(rdy_strb == 1'b0 && ser_do == 1'b0, "R8", "abort during strobe",
        {ser_do, rdy_strb}, 0);
    frame_check("R8", mk_ctrl(3'd0, 1'b1, 1'b0, 2'b11), 10'h21B, 2'b00, 10'h3FF, 0);
    sample_i  = 10'h3FF;
    sub_lsb_i = 2'b11;
    sel_low();
    xfer8(mk_ctrl(3'd5, 1'b1, 1'b0, 2'b11), r, s);
    for (int i = 0; i < 4; i++) bit_cyc(1'b0, o, st);
    repeat (5) @(negedge clk);
    chk(ser_do == 1'b1, "R5", "data bit mid shift", 32'(ser_do), 1);
    sel_high();
    chk(ser_do == 1'b0 && rdy_strb == 1'b0, "R8", "abort mid shift",
        {ser_do, rdy_strb}, 0);
    frame_check("R8", mk_ctrl(3'd3, 1'b0, 1'b0, 2'b11), 10'h0F1, 2'b10, 10'h000, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_bipolar();
    t_sel_high_ignored();
    t_internal();
    t_readout_ignores_di();
    t_abort();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule